// File: doc/BRIEF.md
# Debug Address Trigger Matcher

This block checks each memory access of a hart against a bank of debug triggers. An access can be an instruction fetch, a load or a store. Each trigger holds a 64-bit control word and a 64-bit compare value. When a trigger matches, the block reports a hit, the trigger number and the action to take, which is either a breakpoint exception or entry into debug mode.

A trigger can be linked to its upper neighbour through a chain bit. A linked group fires only when every member matches the same access. The block also filters on the current privilege level and on the access kind. While the hart is in machine mode, triggers fire only if the machine trigger-enable input is set. Nothing fires while the hart is in debug mode. The number of triggers (`NTRIG`, at least 2) and the longest legal chain (`CHAIN_MAX`) are parameters. The results are registered and appear one cycle after the access.

Top module: `dbg_trig_match`

## Requirements
- R1: After reset, `hit`, `hit_idx` and `hit_act` are all 0.
- R2: Only a trigger whose control bits 63:60 equal 2 can match. Type 15 (disabled) and every other type never fire.
- R3: Control bits 10:7 select the compare. Value 2 means address >= compare value. Value 3 means address < compare value. Every other value means address == compare value. All compares are unsigned over 64 bits.
- R4: `priv` is coded 0 = user, 1 = supervisor, 3 = machine. A trigger can match only if its enable bit for the current level is set: bit 3 for user, bit 4 for supervisor, bit 6 for machine. The value `priv` = 2 never matches.
- R5: `acc_kind` is coded 0 = fetch, 1 = load, 2 = store. A trigger can match only if its bit for that kind is set: bit 2 for fetch, bit 0 for load, bit 1 for store. The value `acc_kind` = 3 never matches.
- R6: `hit_act` is 1 (enter debug mode) only when the action field (bits 15:12) of the deciding trigger is 1 and that trigger's bit 59 is set. In every other case `hit_act` is 0 (breakpoint exception).
- R7: When bit 11 of trigger i is set, trigger i and trigger i+1 form one group. The group fires only if all of its members match. The reported index is the group's lowest member, and the action comes from its highest member. Bit 11 of the last trigger is ignored.
- R8: A group with more than `CHAIN_MAX` set link bits never fires.
- R9: When `priv` is 3, nothing fires unless `mach_trig_en` is 1.
- R10: When several groups fire on the same access, the one with the lowest index is reported.
- R11: The outputs are registered. `hit` is 1 in the cycle after an access that had `acc_valid` high and fired. It is 0 after a cycle with `acc_valid` low or with `dbg_mode` high. Whenever `hit` is 0, `hit_idx` and `hit_act` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_flat | input | 64*NTRIG | Control words; trigger i occupies bits 64*i+63 down to 64*i |
| cmp_flat | input | 64*NTRIG | Compare values, packed the same way as the control words |
| priv | input | 2 | Current privilege level |
| dbg_mode | input | 1 | Hart is in debug mode |
| mach_trig_en | input | 1 | Machine-mode trigger enable |
| acc_valid | input | 1 | An access is present this cycle |
| acc_kind | input | 2 | Access kind |
| acc_addr | input | 64 | Access address |
| hit | output | 1 | A trigger group fired on the previous access |
| hit_idx | output | clog2(NTRIG) | Lowest index of the firing group |
| hit_act | output | 1 | 1 = enter debug mode, 0 = breakpoint exception |

## Verification
The assertions check on every cycle that no hit follows a cycle with no valid access, a cycle in debug mode, or a machine-mode cycle with the enable off. They also check that the index stays in range and that the action and index are 0 whenever there is no hit.

Compare modes, privilege and kind filtering, chaining and chain-length limits, and action fallback all depend on the contents of the control words. The bench scenarios cover these by comparing every cycle against a group-scanning reference model.

// File: rtl/dbg_trig_match.sv
module dbg_trig_match #(
  parameter int NTRIG = 4,
  parameter int CHAIN_MAX = 2,
  localparam int IW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [64*NTRIG-1:0]   ctrl_flat,
  input  logic [64*NTRIG-1:0]   cmp_flat,
  input  logic [1:0]            priv,
  input  logic                  dbg_mode,
  input  logic                  mach_trig_en,
  input  logic                  acc_valid,
  input  logic [1:0]            acc_kind,
  input  logic [63:0]           acc_addr,
  output logic                  hit,
  output logic [IW-1:0]         hit_idx,
  output logic                  hit_act
);

  logic [NTRIG-1:0] m, link, dbg_act, start, ok, fire;

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    logic [63:0] c, v;
    logic pe, ke, cm;
    assign c = ctrl_flat[g*64 +: 64];
    assign v = cmp_flat[g*64 +: 64];
    assign pe = (priv == 2'd3 && c[6] && mach_trig_en) ||
                (priv == 2'd1 && c[4]) ||
                (priv == 2'd0 && c[3]);
    assign ke = (acc_kind == 2'd0 && c[2]) ||
                (acc_kind == 2'd1 && c[0]) ||
                (acc_kind == 2'd2 && c[1]);
    always_comb begin
      case (c[10:7])
        4'd2:    cm = acc_addr >= v;
        4'd3:    cm = acc_addr < v;
        default: cm = acc_addr == v;
      endcase
    end
    assign m[g] = (c[63:60] == 4'd2) && pe && ke && cm;
    assign dbg_act[g] = (c[15:12] == 4'd1) && c[59];
    if (g == NTRIG - 1) begin : g_top
      assign link[g] = 1'b0;
    end else begin : g_low
      assign link[g] = c[11];
    end
  end

  assign start = ~{link[NTRIG-2:0], 1'b0};

  int lnk [NTRIG];
  int lst [NTRIG];

  always_comb begin
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (link[i] && i < NTRIG - 1) begin
        ok[i]  = m[i] && ok[i+1];
        lnk[i] = lnk[i+1] + 1;
        lst[i] = lst[i+1];
      end else begin
        ok[i]  = m[i];
        lnk[i] = 0;
        lst[i] = i;
      end
      fire[i] = start[i] && ok[i] && (lnk[i] <= CHAIN_MAX);
    end
  end

  logic          nxt_act;
  logic [IW-1:0] nxt_idx;

  always_comb begin
    nxt_idx = '0;
    nxt_act = 1'b0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (fire[i]) begin
        nxt_idx = IW'(i);
        nxt_act = dbg_act[lst[i]];
      end
    end
  end

  logic go;
  assign go = acc_valid && !dbg_mode && (|fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      hit_idx <= '0;
      hit_act <= 1'b0;
    end else begin
      hit     <= go;
      hit_idx <= go ? nxt_idx : '0;
      hit_act <= go && nxt_act;
    end
  end

endmodule

module dbg_trig_match_chk #(
  parameter int NTRIG = 4,
  localparam int IW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    priv,
  input logic          dbg_mode,
  input logic          mach_trig_en,
  input logic          acc_valid,
  input logic          hit,
  input logic [IW-1:0] hit_idx,
  input logic          hit_act
);

  assert_idle_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!acc_valid) |-> !hit);

  assert_dbg_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_mode) |-> !hit);

  assert_mach_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(priv == 2'd3 && !mach_trig_en) |-> !hit);

  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(hit_idx) < NTRIG));

  assert_quiet_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!hit_act && hit_idx == '0));

endmodule

bind dbg_trig_match dbg_trig_match_chk #(.NTRIG(NTRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .dbg_mode(dbg_mode),
  .mach_trig_en(mach_trig_en), .acc_valid(acc_valid),
  .hit(hit), .hit_idx(hit_idx), .hit_act(hit_act)
);

// File: tb/dbg_trig_match_test.sv
module dbg_trig_match_test;
  localparam int N = 4;
  localparam int CM = 2;

  logic clk = 0, rst_n = 0;
  logic [64*N-1:0] ctrl_flat, cmp_flat;
  logic [1:0] priv, acc_kind;
  logic dbg_mode, mach_trig_en, acc_valid;
  logic [63:0] acc_addr;
  logic hit, hit_act;
  logic [1:0] hit_idx;

  logic [63:0] ctl [N];
  logic [63:0] cmpv [N];
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  dbg_trig_match #(.NTRIG(N), .CHAIN_MAX(CM)) uut (.*);

  always_comb for (int i = 0; i < N; i++) begin
    ctrl_flat[i*64 +: 64] = ctl[i];
    cmp_flat[i*64 +: 64]  = cmpv[i];
  end

  function automatic logic [63:0] mk(int typ, bit dm, int act, bit ch, int mode,
                                     bit pm, bit ps, bit pu, bit x, bit st, bit ld);
    logic [63:0] w = '0;
    w[63:60] = 4'(typ); w[59] = dm; w[15:12] = 4'(act); w[11] = ch;
    w[10:7] = 4'(mode); w[6] = pm; w[4] = ps; w[3] = pu;
    w[2] = x; w[1] = st; w[0] = ld;
    return w;
  endfunction

  function automatic bit one_match(int i);
    logic [63:0] w = ctl[i];
    bit pr, kd, cp;
    if (w[63:60] != 4'd2) return 0;
    case (priv)
      2'd0: pr = w[3];
      2'd1: pr = w[4];
      2'd3: pr = w[6] && mach_trig_en;
      default: pr = 0;
    endcase
    case (acc_kind)
      2'd0: kd = w[2];
      2'd1: kd = w[0];
      2'd2: kd = w[1];
      default: kd = 0;
    endcase
    if (w[10:7] == 4'd2) cp = acc_addr >= cmpv[i];
    else if (w[10:7] == 4'd3) cp = acc_addr < cmpv[i];
    else cp = acc_addr == cmpv[i];
    return pr && kd && cp;
  endfunction

  task automatic model(output bit eh, output int ei, output bit ea);
    int i = 0;
    eh = 0; ei = 0; ea = 0;
    if (!acc_valid || dbg_mode) return;
    while (i < N) begin
      int j = i;
      bit all = 1;
      while (j < N - 1 && ctl[j][11]) j++;
      for (int k = i; k <= j; k++) all &= one_match(k);
      if (all && (j - i) <= CM) begin
        eh = 1; ei = i;
        ea = (ctl[j][15:12] == 4'd1) && ctl[j][59];
        return;
      end
      i = j + 1;
    end
  endtask

  task automatic clear();
    for (int i = 0; i < N; i++) begin ctl[i] = mk(15,0,0,0,0,0,0,0,0,0,0); cmpv[i] = '0; end
  endtask

  task automatic step(string tag, bit v, logic [1:0] kd, logic [63:0] a);
    bit eh, ea; int ei;
    @(negedge clk);
    acc_valid = v; acc_kind = kd; acc_addr = a;
    model(eh, ei, ea);
    @(posedge clk); #1;
    compared++;
    if (hit !== eh || (eh && int'(hit_idx) != ei) || hit_act !== ea) begin
      mismatched++;
      $display("FAIL %s: hit/idx/act got %0b/%0d/%0b expected %0b/%0d/%0b",
               tag, hit, hit_idx, hit_act, eh, ei, ea);
    end
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    clear();
    priv = 2'd3; dbg_mode = 0; mach_trig_en = 1; acc_valid = 0; acc_kind = 0; acc_addr = 0;
    repeat (3) @(posedge clk);
    #1;
    compared++;
    if (hit !== 0 || hit_idx !== 0 || hit_act !== 0) begin
      mismatched++;
      $display("FAIL R1: got %0b/%0d/%0b expected 0/0/0", hit, hit_idx, hit_act);
    end
    rst_n = 1;

    // R2 types
    ctl[0] = mk(2,0,0,0,0,1,0,0,1,0,0); cmpv[0] = 64'h100;
    step("R2", 1, 0, 64'h100);
    ctl[0][63:60] = 4'd15; step("R2", 1, 0, 64'h100);
    ctl[0][63:60] = 4'd6;  step("R2", 1, 0, 64'h100);

    // R3 compare modes
    clear(); ctl[0] = mk(2,0,0,0,2,1,0,0,1,0,0); cmpv[0] = 64'h200;
    step("R3", 1, 0, 64'h200); step("R3", 1, 0, 64'h1FF);
    cmpv[0] = 64'h1; step("R3", 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    ctl[0][10:7] = 4'd3; cmpv[0] = 64'h200;
    step("R3", 1, 0, 64'h1FF); step("R3", 1, 0, 64'h200);
    ctl[0][10:7] = 4'd5; step("R3", 1, 0, 64'h200); step("R3", 1, 0, 64'h201);

    // R4 privilege
    clear(); ctl[0] = mk(2,0,0,0,0,1,0,0,1,1,1); cmpv[0] = 64'h40;
    priv = 0; step("R4", 1, 0, 64'h40);
    ctl[0][3] = 1; step("R4", 1, 0, 64'h40);
    priv = 1; step("R4", 1, 0, 64'h40);
    ctl[0][4] = 1; step("R4", 1, 0, 64'h40);
    priv = 2; step("R4", 1, 0, 64'h40);
    priv = 3;

    // R5 access kind
    clear(); ctl[0] = mk(2,0,0,0,0,1,0,0,0,1,0); cmpv[0] = 64'h80;
    step("R5", 1, 1, 64'h80); step("R5", 1, 2, 64'h80); step("R5", 1, 0, 64'h80);
    ctl[0] = mk(2,0,0,0,0,1,0,0,1,1,1); step("R5", 1, 3, 64'h80);
    step("R5", 1, 1, 64'h80);

    // R6 action
    clear(); ctl[0] = mk(2,0,1,0,0,1,0,0,1,0,0); cmpv[0] = 64'h10;
    step("R6", 1, 0, 64'h10);
    ctl[0][59] = 1; step("R6", 1, 0, 64'h10);
    ctl[0][15:12] = 4'd4; step("R6", 1, 0, 64'h10);

    // R7 chaining
    clear();
    ctl[0] = mk(2,0,0,1,0,1,0,0,1,0,0); cmpv[0] = 64'h500;
    ctl[1] = mk(2,1,1,0,2,1,0,0,1,0,0); cmpv[1] = 64'h600;
    step("R7", 1, 0, 64'h500);
    cmpv[1] = 64'h400; step("R7", 1, 0, 64'h500);
    ctl[3] = mk(2,0,0,1,0,1,0,0,1,0,0); cmpv[3] = 64'h500; cmpv[1] = 64'h600;
    step("R7", 1, 0, 64'h500);

    // R8 chain too long
    clear();
    for (int i = 0; i < N; i++) begin ctl[i] = mk(2,0,0,i<3,0,1,0,0,1,0,0); cmpv[i] = 64'h700; end
    step("R8", 1, 0, 64'h700);
    ctl[2][11] = 0; step("R8", 1, 0, 64'h700);

    // R9 machine gating
    clear(); ctl[0] = mk(2,0,0,0,0,1,1,0,1,0,0); cmpv[0] = 64'h90;
    mach_trig_en = 0; step("R9", 1, 0, 64'h90);
    priv = 1; step("R9", 1, 0, 64'h90);
    priv = 3; mach_trig_en = 1; step("R9", 1, 0, 64'h90);

    // R10 priority
    clear();
    ctl[1] = mk(2,0,0,0,0,1,0,0,1,0,0); cmpv[1] = 64'hA0;
    ctl[3] = mk(2,1,1,0,2,1,0,0,1,0,0); cmpv[3] = 64'h0;
    step("R10", 1, 0, 64'hA0); step("R10", 1, 0, 64'hA1);

    // R11 timing and gating
    step("R11", 0, 0, 64'hA0);
    step("R11", 1, 0, 64'hA0);
    step("R11", 0, 0, 64'hA0);
    dbg_mode = 1; step("R11", 1, 0, 64'hA0);
    dbg_mode = 0; step("R11", 1, 0, 64'hA0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule